// File: doc/BRIEF.md
# Capture Pixel Format Packer

This block sits between a video decoder and a memory write FIFO. Each cycle it can take one decoded pixel, offered as 8-bit red, green and blue components together with one 8-bit luma sample and one 8-bit chroma sample. It turns that pixel into the bytes of the selected memory format and packs those bytes into a stream of 32-bit words, with a valid/ready handshake on both sides. The source provides the 4:2:2 chroma alternation itself: it sends U with even pixels and V with odd pixels on the chroma input.

A 3-bit format code selects one of five output formats. There are two 16-bit RGB layouts, packed 24-bit RGB, 32-bit RGB and packed 4:2:2. Two more controls reorder the bytes. The byte-swap control gives the big-endian counterpart of each format. The word-swap control exchanges the two 16-bit halves of each output word. The source marks the last pixel of each line. When that pixel arrives, the block emits any partly filled word and reports how many bytes the line held.

Top module: `pixel_packer`

## Requirements
- R1: Format code 0 builds the 16-bit value {1'b0, R[7:3], G[7:3], B[7:3]} and code 1 builds {R[7:3], G[7:2], B[7:3]}. Without byte-swap the low byte of that value is emitted first. With byte-swap the high byte is emitted first.
- R2: Format code 2 emits three bytes per pixel. The order is B, G, R without byte-swap and R, G, B with byte-swap. Pixels are packed back to back across word boundaries, so four pixels fill exactly three words.
- R3: Format code 3 emits four bytes per pixel. The order is B, G, R, 0 without byte-swap and G, B, 0, R with byte-swap. With both byte-swap and word-swap set, the word therefore holds 0, R, G, B in stream order.
- R4: Format code 4 emits two bytes per pixel. The order is luma then chroma without byte-swap (Y-U-Y-V over a pixel pair) and chroma then luma with byte-swap (U-Y-V-Y).
- R5: With word-swap set, every word emitted for the line has its bits [15:0] and [31:16] exchanged. This applies to every format and also to the final flushed word.
- R6: Format codes 5, 6 and 7 produce exactly the output of code 0.
- R7: Stream byte k of a word goes to out_data[8k+7:8k], before any word-swap. Words leave in stream order, and no word is lost, duplicated or added.
- R8: When the last pixel of a line leaves bytes that do not fill a word, the block emits those bytes as one more word with the unused upper bytes set to zero. The next line starts on a fresh word.
- R9: The format code and both swap controls are taken from the first pixel of each line. Changes to them while the line is in progress have no effect until the next line.
- R10: line_done pulses high for one cycle, in the cycle after the last pixel of a line is accepted. In that cycle line_bytes equals the number of pixels in the line times the depth, divided by 8. The depth is 16 for codes 0, 1, 4, 5, 6 and 7, 24 for code 2, and 32 for code 3.
- R11: While out_valid is high and out_ready is low, out_valid and out_data hold their values. pix_ready is low whenever the output word is stalled or a line-end flush is still waiting.
- R12: After reset, out_valid is 0, line_done is 0 and pix_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Output format code |
| cfg_bswap | input | 1 | Byte-swap control |
| cfg_wswap | input | 1 | Word-swap control |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be taken this cycle |
| pix_last | input | 1 | Offered pixel is the last of its line |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_y | input | 8 | Luma sample |
| pix_c | input | 8 | Chroma sample (U or V) |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | 32 | Packed output word |
| line_done | output | 1 | One-cycle pulse at end of line |
| line_bytes | output | LB_W | Byte count of the line just finished |

## Verification
The hardest case is a pixel that arrives in the same cycle as a stalled or just-draining output word. It is hardest when that pixel is the last of a line and produces a full word plus a remainder that must still be flushed. The bench provokes this with short lines of 24-bit and 32-bit pixels, odd pixel counts, randomly gapped input and a randomly throttled or fully held out_ready. A behavioural byte-queue model checks every word taken at the output against the expected stream. It also checks that pix_ready drops while a word is stalled, and that line_done and line_bytes appear exactly one cycle after the last pixel, whatever the output backpressure is doing.

// File: rtl/pack_pkg.sv
package pack_pkg;

  localparam int COMP_W = 8;
  localparam int WORD_BYTES = 4;
  localparam int HOLD_BYTES = WORD_BYTES - 1;
  localparam int MERGE_BYTES = HOLD_BYTES + WORD_BYTES;

  typedef enum logic [2:0] {
    FMT_RGB15 = 3'd0,
    FMT_RGB16 = 3'd1,
    FMT_RGB24 = 3'd2,
    FMT_RGB32 = 3'd3,
    FMT_YC422 = 3'd4
  } fmt_e;

  typedef struct packed {
    logic [2:0] fmt;
    logic       bswap;
    logic       wswap;
  } cfg_t;

  function automatic logic [31:0] swap_halves(input logic [31:0] w, input logic en);
    return en ? {w[15:0], w[31:16]} : w;
  endfunction

endpackage

// File: rtl/pixel_bytes.sv
module pixel_bytes
  import pack_pkg::*;
(
  input  logic [2:0]                  fmt,
  input  logic                        bswap,
  input  logic [COMP_W-1:0]           r,
  input  logic [COMP_W-1:0]           g,
  input  logic [COMP_W-1:0]           b,
  input  logic [COMP_W-1:0]           y,
  input  logic [COMP_W-1:0]           c,
  output logic [WORD_BYTES-1:0][7:0]  px_bytes,
  output logic [2:0]                  px_cnt
);

  logic [15:0] v16;

  always_comb begin
    px_bytes = '0;
    px_cnt   = 3'd2;
    v16      = {1'b0, r[7:3], g[7:3], b[7:3]};
    case (fmt)
      FMT_RGB16: begin
        v16 = {r[7:3], g[7:2], b[7:3]};
        px_bytes[0] = bswap ? v16[15:8] : v16[7:0];
        px_bytes[1] = bswap ? v16[7:0]  : v16[15:8];
      end
      FMT_RGB24: begin
        px_cnt = 3'd3;
        px_bytes[0] = bswap ? r : b;
        px_bytes[1] = g;
        px_bytes[2] = bswap ? b : r;
      end
      FMT_RGB32: begin
        px_cnt = 3'd4;
        if (bswap) begin
          px_bytes[0] = g;
          px_bytes[1] = b;
          px_bytes[2] = 8'h00;
          px_bytes[3] = r;
        end else begin
          px_bytes[0] = b;
          px_bytes[1] = g;
          px_bytes[2] = r;
          px_bytes[3] = 8'h00;
        end
      end
      FMT_YC422: begin
        px_bytes[0] = bswap ? c : y;
        px_bytes[1] = bswap ? y : c;
      end
      default: begin
        px_bytes[0] = bswap ? v16[15:8] : v16[7:0];
        px_bytes[1] = bswap ? v16[7:0]  : v16[15:8];
      end
    endcase
  end

endmodule

// File: rtl/word_packer.sv
module word_packer
  import pack_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        pix_valid,
  input  logic                        pix_last,
  input  logic [WORD_BYTES-1:0][7:0]  px_bytes,
  input  logic [2:0]                  px_cnt,
  input  logic                        wswap_now,
  input  logic                        wswap_line,
  input  logic                        out_ready,
  output logic                        pix_ready,
  output logic                        take,
  output logic                        out_valid,
  output logic [31:0]                 out_data
);

  logic [HOLD_BYTES-1:0][7:0]  pend, pend_nx;
  logic [1:0]                  pend_n, pend_n_nx;
  logic                        flush_pend, flush_nx;
  logic                        ov_nx;
  logic [31:0]                 od_nx;
  logic [MERGE_BYTES-1:0][7:0] merged;
  logic [2:0]                  total;
  logic                        slot_free, emit, sw;
  logic [31:0]                 word;
  int                          j;

  assign slot_free = !out_valid || out_ready;
  assign pix_ready = slot_free && !flush_pend;
  assign take      = pix_valid && pix_ready;
  assign total     = 3'(pend_n) + px_cnt;

  // held bytes first, then the new pixel's bytes, zero above
  always_comb begin
    merged = '0;
    j = 0;
    for (int i = 0; i < MERGE_BYTES; i++) begin
      if (i < int'(pend_n)) begin
        merged[i] = pend[i[1:0]];
      end else begin
        j = i - int'(pend_n);
        if (j < int'(px_cnt)) merged[i] = px_bytes[j[1:0]];
      end
    end
  end

  always_comb begin
    pend_nx   = pend;
    pend_n_nx = pend_n;
    flush_nx  = flush_pend;
    emit      = 1'b0;
    sw        = 1'b0;
    word      = {merged[3], merged[2], merged[1], merged[0]};
    if (take) begin
      sw = wswap_now;
      if (total >= 3'd4) begin
        emit      = 1'b1;
        pend_nx   = {merged[6], merged[5], merged[4]};
        pend_n_nx = 2'(total - 3'd4);
        flush_nx  = pix_last && (total != 3'd4);
      end else if (pix_last) begin
        emit      = 1'b1;
        pend_nx   = '0;
        pend_n_nx = 2'd0;
      end else begin
        pend_nx   = {merged[2], merged[1], merged[0]};
        pend_n_nx = total[1:0];
      end
    end else if (flush_pend && slot_free) begin
      emit      = 1'b1;
      sw        = wswap_line;
      word      = {8'h00, pend[2], pend[1], pend[0]};
      pend_nx   = '0;
      pend_n_nx = 2'd0;
      flush_nx  = 1'b0;
    end
    ov_nx = out_valid;
    od_nx = out_data;
    if (emit) begin
      ov_nx = 1'b1;
      od_nx = swap_halves(word, sw);
    end else if (out_ready) begin
      ov_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend       <= '0;
      pend_n     <= 2'd0;
      flush_pend <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      pend       <= pend_nx;
      pend_n     <= pend_n_nx;
      flush_pend <= flush_nx;
      out_valid  <= ov_nx;
      out_data   <= od_nx;
    end
  end

  // R11: stalled word is held
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11: no pixel enters while a flush waits
  a_r11_no_take_in_flush: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_pend |-> !take);

  // R8: a flush leaves nothing behind
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_pend && slot_free |=> !flush_pend && pend_n == 2'd0 && out_valid);

endmodule

// File: rtl/line_meter.sv
module line_meter #(
  parameter int LB_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            take,
  input  logic            pix_last,
  input  logic [2:0]      px_cnt,
  output logic            line_done,
  output logic [LB_W-1:0] line_bytes
);

  logic [LB_W-1:0] cnt, cnt_nx, lb_nx, sum;
  logic            done_nx;

  assign sum = cnt + LB_W'(px_cnt);

  always_comb begin
    cnt_nx  = cnt;
    lb_nx   = line_bytes;
    done_nx = 1'b0;
    if (take) begin
      if (pix_last) begin
        lb_nx   = sum;
        cnt_nx  = '0;
        done_nx = 1'b1;
      end else begin
        cnt_nx  = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      line_bytes <= '0;
      line_done  <= 1'b0;
    end else begin
      cnt        <= cnt_nx;
      line_bytes <= lb_nx;
      line_done  <= done_nx;
    end
  end

  // R10: a finished line always holds at least one 16-bit pixel
  a_r10_count_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    line_done |-> line_bytes >= LB_W'(2));

  // R10: the pulse follows an accepted last pixel
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    take && pix_last |=> line_done && cnt == '0);

endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
  import pack_pkg::*;
#(
  parameter int LB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_fmt,
  input  logic            cfg_bswap,
  input  logic            cfg_wswap,
  input  logic            pix_valid,
  output logic            pix_ready,
  input  logic            pix_last,
  input  logic [7:0]      pix_r,
  input  logic [7:0]      pix_g,
  input  logic [7:0]      pix_b,
  input  logic [7:0]      pix_y,
  input  logic [7:0]      pix_c,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_data,
  output logic            line_done,
  output logic [LB_W-1:0] line_bytes
);

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cfg_t cfg_in, cfg_q, cfg_q_nx, cur_cfg;
  logic line_start, line_start_nx;
  logic take;
  logic [WORD_BYTES-1:0][7:0] px_bytes;
  logic [2:0] px_cnt;

  assign cfg_in  = {cfg_fmt, cfg_bswap, cfg_wswap};
  assign cur_cfg = line_start ? cfg_in : cfg_q;

  always_comb begin
    cfg_q_nx      = cfg_q;
    line_start_nx = line_start;
    if (take) begin
      if (line_start) cfg_q_nx = cfg_in;
      line_start_nx = pix_last;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      line_start <= 1'b1;
    end else begin
      cfg_q      <= cfg_q_nx;
      line_start <= line_start_nx;
    end
  end

  pixel_bytes u_bytes (
    .fmt      (cur_cfg.fmt),
    .bswap    (cur_cfg.bswap),
    .r        (pix_r),
    .g        (pix_g),
    .b        (pix_b),
    .y        (pix_y),
    .c        (pix_c),
    .px_bytes (px_bytes),
    .px_cnt   (px_cnt)
  );

  word_packer u_pack (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .pix_valid  (pix_valid),
    .pix_last   (pix_last),
    .px_bytes   (px_bytes),
    .px_cnt     (px_cnt),
    .wswap_now  (cur_cfg.wswap),
    .wswap_line (cfg_q.wswap),
    .out_ready  (out_ready),
    .pix_ready  (pix_ready),
    .take       (take),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  line_meter #(.LB_W(LB_W)) u_meter (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .take       (take),
    .pix_last   (pix_last),
    .px_cnt     (px_cnt),
    .line_done  (line_done),
    .line_bytes (line_bytes)
  );

  // R9: line settings frozen between line start and line end
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    !line_start |=> $stable(cfg_q));

endmodule

// File: tb/tb_pixel_packer.sv
`timescale 1ns/1ps
module tb_pixel_packer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_fmt;
  logic        cfg_bswap, cfg_wswap;
  logic        pix_valid, pix_ready, pix_last;
  logic [7:0]  pix_r, pix_g, pix_b, pix_y, pix_c;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        line_done;
  logic [15:0] line_bytes;

  always #4 clk = ~clk;

  pixel_packer #(.LB_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_bswap(cfg_bswap),
    .cfg_wswap(cfg_wswap), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_last(pix_last), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_y(pix_y), .pix_c(pix_c), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .line_done(line_done), .line_bytes(line_bytes)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  int words_seen = 0;
  bit mon_en = 0;
  bit stall = 0;
  bit rnd_ready = 1;
  bit scramble = 0;

  // reference model state
  logic [7:0]  bq[$];
  logic [31:0] expw[$];
  string       tagq[$];
  int          expl[$];
  bit          m_start = 1;
  int          m_fmt;
  bit          m_bs, m_ws;
  string       m_tag;
  int          m_bytes;
  bit          done_due = 0;
  bit          p_ov = 0, p_or = 0;
  logic [31:0] p_od = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int depth_of(input int f);
    if (f == 2) return 24;
    if (f == 3) return 32;
    return 16;
  endfunction

  function automatic string tag_of(input int f, input bit ws);
    if (scramble) return "R9";
    if (ws) return "R5";
    case (f)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic push_word(input string t);
    logic [31:0] w;
    w = {bq[3], bq[2], bq[1], bq[0]};
    repeat (4) void'(bq.pop_front());
    if (m_ws) w = {w[15:0], w[31:16]};
    expw.push_back(w);
    tagq.push_back(t);
  endtask

  task automatic model_accept();
    logic [15:0] v;
    if (m_start) begin
      m_fmt = int'(cfg_fmt); m_bs = cfg_bswap; m_ws = cfg_wswap;
      m_tag = tag_of(m_fmt, m_ws);
      m_bytes = 0;
    end
    case (m_fmt)
      2: begin
        if (m_bs) begin bq.push_back(pix_r); bq.push_back(pix_g); bq.push_back(pix_b); end
        else      begin bq.push_back(pix_b); bq.push_back(pix_g); bq.push_back(pix_r); end
      end
      3: begin
        if (m_bs) begin bq.push_back(pix_g); bq.push_back(pix_b); bq.push_back(8'h00); bq.push_back(pix_r); end
        else      begin bq.push_back(pix_b); bq.push_back(pix_g); bq.push_back(pix_r); bq.push_back(8'h00); end
      end
      4: begin
        if (m_bs) begin bq.push_back(pix_c); bq.push_back(pix_y); end
        else      begin bq.push_back(pix_y); bq.push_back(pix_c); end
      end
      default: begin
        if (m_fmt == 1) v = {pix_r[7:3], pix_g[7:2], pix_b[7:3]};
        else            v = {1'b0, pix_r[7:3], pix_g[7:3], pix_b[7:3]};
        if (m_bs) begin bq.push_back(v[15:8]); bq.push_back(v[7:0]); end
        else      begin bq.push_back(v[7:0]);  bq.push_back(v[15:8]); end
      end
    endcase
    m_bytes += depth_of(m_fmt) / 8;
    while (bq.size() >= 4) push_word(m_tag);
    if (pix_last) begin
      if (bq.size() > 0) begin
        while (bq.size() < 4) bq.push_back(8'h00);
        push_word("R8");
      end
      expl.push_back(m_bytes);
      done_due = 1;
    end
    m_start = pix_last;
  endtask

  // monitor, 1 ns before each rising edge
  always @(negedge clk) begin
    #3;
    if (mon_en) begin
      bit due;
      due = done_due;
      done_due = 0;
      if (p_ov && !p_or)
        chk(out_valid && out_data == p_od, "R11 hold", out_data, p_od);
      if (out_valid && !out_ready)
        chk(!pix_ready, "R11 ready", {31'd0, pix_ready}, 32'd0);
      if (line_done || due) begin
        chk(line_done == due, "R10 pulse", {31'd0, line_done}, {31'd0, due});
        if (line_done && expl.size() > 0) begin
          int e;
          e = expl.pop_front();
          chk(int'(line_bytes) == e, "R10 bytes", {16'd0, line_bytes}, e);
        end
      end
      if (out_valid && out_ready) begin
        words_seen++;
        if (expw.size() == 0) chk(0, "R7 extra word", out_data, 32'd0);
        else begin
          logic [31:0] e;
          string t;
          e = expw.pop_front();
          t = tagq.pop_front();
          chk(out_data == e, t, out_data, e);
        end
      end
      if (pix_valid && pix_ready) model_accept();
      p_ov = out_valid; p_or = out_ready; p_od = out_data;
    end
  end

  always @(negedge clk) begin
    if (stall) out_ready = 1'b0;
    else if (rnd_ready) out_ready = ($urandom % 4) != 0;
    else out_ready = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send_line(input int n, input int f, input bit bs, input bit ws);
    for (int i = 0; i < n; i++) begin
      bit done;
      @(negedge clk);
      while (($urandom % 5) == 0) begin
        pix_valid = 1'b0;
        @(negedge clk);
      end
      if (i == 0 || !scramble) begin
        cfg_fmt = 3'(f); cfg_bswap = bs; cfg_wswap = ws;
      end else begin
        cfg_fmt = 3'($urandom); cfg_bswap = 1'($urandom); cfg_wswap = 1'($urandom);
      end
      pix_valid = 1'b1;
      pix_last = (i == n - 1);
      pix_r = 8'($urandom); pix_g = 8'($urandom); pix_b = 8'($urandom);
      pix_y = 8'($urandom); pix_c = 8'($urandom);
      done = 0;
      while (!done) begin
        #3;
        done = pix_ready;
        if (!done) @(negedge clk);
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_last = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((expw.size() != 0 || out_valid || expl.size() != 0) && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_fmt = 3'd0; cfg_bswap = 0; cfg_wswap = 0;
    pix_valid = 0; pix_last = 0;
    pix_r = 0; pix_g = 0; pix_b = 0; pix_y = 0; pix_c = 0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk(line_done == 1'b0, "R12 line_done", {31'd0, line_done}, 32'd0);
    chk(pix_ready == 1'b1, "R12 pix_ready", {31'd0, pix_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk(out_valid == 1'b0 && pix_ready == 1'b1, "R12 after release",
        {30'd0, out_valid, pix_ready}, 32'd1);
    @(negedge clk);
    mon_en = 1;

    // every base format and swap combination, odd and even lengths
    for (int f = 0; f < 5; f++)
      for (int s = 0; s < 4; s++) begin
        send_line(5 + f, f, s[0], s[1]);
        send_line(4, f, s[0], s[1]);
      end
    drain();

    // R2: four packed 24-bit pixels give exactly three words
    begin
      int w0;
      w0 = words_seen;
      send_line(4, 2, 0, 0);
      drain();
      chk(words_seen - w0 == 3, "R2 word count", words_seen - w0, 3);
    end

    // R6: reserved codes behave as code 0
    for (int f = 5; f < 8; f++) send_line(6, f, f[0], 0);
    drain();

    // R9: settings change on every pixel after the first
    scramble = 1;
    for (int k = 0; k < 6; k++) send_line(7, k % 5, k[0], k[1]);
    scramble = 0;
    drain();

    // R11: output held off while a 24-bit line is offered
    fork
      begin
        stall = 1;
        repeat (40) @(negedge clk);
        stall = 0;
      end
    join_none
    send_line(9, 2, 1, 1);
    send_line(1, 3, 0, 1);
    send_line(1, 2, 0, 0);
    drain();

    // back-to-back short lines with full-rate output
    rnd_ready = 0;
    for (int k = 0; k < 8; k++) send_line(1 + (k % 3), k % 5, k[1], k[2]);
    drain();
    rnd_ready = 1;

    // R10: full-width 24-bit line
    send_line(720, 2, 0, 0);
    drain();

    chk(expw.size() == 0, "R7 words outstanding", expw.size(), 0);
    chk(expl.size() == 0, "R10 lines outstanding", expl.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule